// File: doc/BRIEF.md
# DMA Page Translation Unit

This block turns logical DMA addresses into physical addresses. It looks each one up in a table of page frames held inside the unit. Pages are 4096 bytes. The upper bits of a logical address pick a table entry, and the low twelve bits pass through untouched as the offset within the page. Software fills the table one 32-bit word at a time through a byte-offset write port. Each entry takes eight bytes: a frame word at the lower word address and an owner word above it. Only frame words change the mapping.

Two configuration registers control the table. The base register holds a 31-bit physical location of the table for a fetch engine outside this block. The limit register holds the table length in bytes and sets how many entries are live. A requester presents a logical address with a valid strobe. One clock later it receives a response strobe, a hit or fault flag, and the translated address.

Top module: `dxu_xlate`

## Requirements
- R1: After reset, the response strobe, hit and fault are low. Both configuration readbacks are zero, and every table entry is unmapped, so a lookup faults even once a limit is set.
- R2: A request accepted on a clock edge produces its response strobe exactly one clock later. With no request there is no response.
- R3: On a hit, the physical address is bits 31:12 of the entry's frame word followed by bits 11:0 of the logical address.
- R4: An entry whose 32-bit frame word is zero is unmapped, and a lookup of it faults. A nonzero frame word whose bits 31:12 are zero still maps, to page zero.
- R5: A table write updates entry N only when the byte offset equals 8*N, with offset bits 2:0 all zero. A write at 8*N+4 (the owner word), or at any other offset with nonzero bits 2:0, leaves the mapping unchanged.
- R6: The live entry count is the limit value shifted right by 3. A request whose page index (address bits 31:12) is not below that count faults, and a limit of zero faults every request.
- R7: The live entry count saturates at MAX_ENTRIES (512). A page index of 512 or more always faults, whatever the limit.
- R8: A base write stores the value with bit 31 forced to zero. A limit write stores the value unchanged.
- R9: When a frame write and a lookup of the same entry fall in the same cycle, the lookup returns the mapping stored before that write.
- R10: While the response strobe is high, exactly one of hit and fault is high. While it is low, both are low. The physical address is zero unless hit is high.
- R11: Writing a new frame word over a mapped entry replaces its mapping for all later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | 0 selects the base register, 1 selects the limit register |
| cfg_wdata | input | 32 | Configuration write data |
| tbl_we | input | 1 | Table word write strobe |
| tbl_off | input | 12 | Byte offset of the table word being written |
| tbl_wdata | input | 32 | Table word write data |
| req_valid | input | 1 | Lookup request strobe |
| req_laddr | input | 32 | Logical address to translate |
| rsp_valid | output | 1 | Response strobe, one clock after the request |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Translation refused (unmapped or outside the live range) |
| rsp_paddr | output | 32 | Translated physical address, zero unless hit |
| tbl_base | output | 32 | Stored base register |
| tbl_limit | output | 32 | Stored limit register |

## Verification
The first kind of result appears on the edge after the stimulus. Configuration and table writes show at the readbacks and in later lookups from that edge on, and every lookup response appears on the edge after the request. The bench drives all inputs on falling edges and keeps each strobe high for one cycle. It samples on the next falling edge, half a period after the one rising edge that must produce the result. The cycle after each lookup is also sampled, to confirm that the strobe has dropped. The same-cycle write-and-lookup case is driven in a single falling-edge slot, so that both operations meet the same rising edge.

// File: rtl/dxu_pkg.sv
package dxu_pkg;

   typedef enum logic {
      CFG_BASE  = 1'b0,
      CFG_LIMIT = 1'b1
   } dxu_cfg_sel_e;

   localparam int unsigned DXU_ENTRY_BYTES = 8;
   localparam int unsigned DXU_WORD_BYTES  = 4;

endpackage

// File: rtl/dxu_cfg_regs.sv
module dxu_cfg_regs
   import dxu_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned MAX_ENTRIES = 512,
   parameter int unsigned CNT_W       = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] base_q,
   output logic [DATA_W-1:0] limit_q,
   output logic [CNT_W-1:0]  live_cnt_q
);

   localparam int unsigned ENT_SHIFT = $clog2(DXU_ENTRY_BYTES);

   generate
      if (DATA_W < 2 * ENT_SHIFT) begin : g_bad_width
         $error("dxu_cfg_regs: DATA_W too narrow");
      end
      if ((1 << (CNT_W - 1)) > MAX_ENTRIES || (1 << CNT_W) <= MAX_ENTRIES) begin : g_bad_cnt
         $error("dxu_cfg_regs: CNT_W must be clog2(MAX_ENTRIES)+1");
      end
   endgenerate

   dxu_cfg_sel_e             sel;
   logic [DATA_W-1:0]        ent_raw;
   logic [CNT_W-1:0]         cnt_d;

   assign sel     = dxu_cfg_sel_e'(cfg_sel);
   assign ent_raw = cfg_wdata >> ENT_SHIFT;

   always_comb begin
      if (ent_raw > DATA_W'(MAX_ENTRIES)) cnt_d = CNT_W'(MAX_ENTRIES);
      else                                cnt_d = ent_raw[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q     <= '0;
         limit_q    <= '0;
         live_cnt_q <= '0;
      end else if (cfg_we) begin
         if (sel == CFG_BASE) begin
            base_q <= {1'b0, cfg_wdata[DATA_W-2:0]};
         end else begin
            limit_q    <= cfg_wdata;
            live_cnt_q <= cnt_d;
         end
      end
   end

endmodule

// File: rtl/dxu_entry_store.sv
module dxu_entry_store #(
   parameter int unsigned MAX_ENTRIES = 512,
   parameter int unsigned IDX_W       = 9,
   parameter int unsigned FRAME_W     = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [FRAME_W-1:0] wr_frame,
   input  logic               wr_mapped,
   input  logic               rd_en,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [FRAME_W-1:0] rd_frame,
   output logic               rd_mapped
);

   generate
      if ((1 << IDX_W) != MAX_ENTRIES) begin : g_bad_depth
         $error("dxu_entry_store: MAX_ENTRIES must equal 2**IDX_W");
      end
   endgenerate

   logic [FRAME_W-1:0]     frame_mem [MAX_ENTRIES];
   logic [MAX_ENTRIES-1:0] mapped_q;

   always_ff @(posedge clk) begin
      if (wr_en) frame_mem[wr_idx] <= wr_frame;
      if (rd_en) rd_frame <= frame_mem[rd_idx];
   end

   generate
      for (genvar e = 0; e < MAX_ENTRIES; e++) begin : g_map
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               mapped_q[e] <= 1'b0;
            else if (wr_en && wr_idx == IDX_W'(e))    mapped_q[e] <= wr_mapped;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_mapped <= 1'b0;
      else if (rd_en) rd_mapped <= mapped_q[rd_idx];
   end

endmodule

// File: rtl/dxu_lookup.sv
module dxu_lookup #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned PAGE_BITS = 12,
   parameter int unsigned IDX_W     = 9,
   parameter int unsigned CNT_W     = 10
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic [ADDR_W-1:0]           req_laddr,
   input  logic [CNT_W-1:0]            live_cnt,
   output logic                        rd_en,
   output logic [IDX_W-1:0]            rd_idx,
   input  logic [ADDR_W-PAGE_BITS-1:0] rd_frame,
   input  logic                        rd_mapped,
   output logic                        rsp_valid,
   output logic                        rsp_hit,
   output logic                        rsp_fault,
   output logic [ADDR_W-1:0]           rsp_paddr
);

   localparam int unsigned PIDX_W = ADDR_W - PAGE_BITS;

   generate
      if (PIDX_W < CNT_W) begin : g_bad_split
         $error("dxu_lookup: page index narrower than entry count");
      end
   endgenerate

   logic [PIDX_W-1:0]    page;
   logic                 in_range;
   logic                 stg_vld_q;
   logic                 stg_rng_q;
   logic [PAGE_BITS-1:0] stg_off_q;

   assign page     = req_laddr[ADDR_W-1:PAGE_BITS];
   assign in_range = page < PIDX_W'(live_cnt);
   assign rd_en    = req_valid;
   assign rd_idx   = page[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_vld_q <= 1'b0;
         stg_rng_q <= 1'b0;
         stg_off_q <= '0;
      end else begin
         stg_vld_q <= req_valid;
         if (req_valid) begin
            stg_rng_q <= in_range;
            stg_off_q <= req_laddr[PAGE_BITS-1:0];
         end
      end
   end

   assign rsp_valid = stg_vld_q;
   assign rsp_hit   = stg_vld_q & stg_rng_q & rd_mapped;
   assign rsp_fault = stg_vld_q & ~rsp_hit;
   assign rsp_paddr = rsp_hit ? {rd_frame, stg_off_q} : '0;

endmodule

// File: rtl/dxu_xlate.sv
module dxu_xlate
   import dxu_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned PAGE_BITS   = 12,
   parameter int unsigned MAX_ENTRIES = 512,
   localparam int unsigned IDX_W      = $clog2(MAX_ENTRIES),
   localparam int unsigned CNT_W      = IDX_W + 1,
   localparam int unsigned ENT_SHIFT  = $clog2(DXU_ENTRY_BYTES),
   localparam int unsigned TBL_OFF_W  = IDX_W + ENT_SHIFT
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic                 cfg_sel,
   input  logic [ADDR_W-1:0]    cfg_wdata,
   input  logic                 tbl_we,
   input  logic [TBL_OFF_W-1:0] tbl_off,
   input  logic [ADDR_W-1:0]    tbl_wdata,
   input  logic                 req_valid,
   input  logic [ADDR_W-1:0]    req_laddr,
   output logic                 rsp_valid,
   output logic                 rsp_hit,
   output logic                 rsp_fault,
   output logic [ADDR_W-1:0]    rsp_paddr,
   output logic [ADDR_W-1:0]    tbl_base,
   output logic [ADDR_W-1:0]    tbl_limit
);

   localparam int unsigned FRAME_W = ADDR_W - PAGE_BITS;

   generate
      if (ADDR_W != 8 * DXU_WORD_BYTES) begin : g_bad_word
         $error("dxu_xlate: table words are 32 bits");
      end
      if (PAGE_BITS < ENT_SHIFT || PAGE_BITS >= ADDR_W) begin : g_bad_page
         $error("dxu_xlate: PAGE_BITS out of range");
      end
   endgenerate

   logic [CNT_W-1:0]   live_cnt;
   logic               frame_wr;
   logic [IDX_W-1:0]   wr_idx;
   logic               rd_en;
   logic [IDX_W-1:0]   rd_idx;
   logic [FRAME_W-1:0] rd_frame;
   logic               rd_mapped;

   assign frame_wr = tbl_we && (tbl_off[ENT_SHIFT-1:0] == '0);
   assign wr_idx   = tbl_off[TBL_OFF_W-1:ENT_SHIFT];

   dxu_cfg_regs #(
      .DATA_W      (ADDR_W),
      .MAX_ENTRIES (MAX_ENTRIES),
      .CNT_W       (CNT_W)
   ) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_sel    (cfg_sel),
      .cfg_wdata  (cfg_wdata),
      .base_q     (tbl_base),
      .limit_q    (tbl_limit),
      .live_cnt_q (live_cnt)
   );

   dxu_entry_store #(
      .MAX_ENTRIES (MAX_ENTRIES),
      .IDX_W       (IDX_W),
      .FRAME_W     (FRAME_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (frame_wr),
      .wr_idx    (wr_idx),
      .wr_frame  (tbl_wdata[ADDR_W-1:PAGE_BITS]),
      .wr_mapped (|tbl_wdata),
      .rd_en     (rd_en),
      .rd_idx    (rd_idx),
      .rd_frame  (rd_frame),
      .rd_mapped (rd_mapped)
   );

   dxu_lookup #(
      .ADDR_W    (ADDR_W),
      .PAGE_BITS (PAGE_BITS),
      .IDX_W     (IDX_W),
      .CNT_W     (CNT_W)
   ) u_look (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_laddr (req_laddr),
      .live_cnt  (live_cnt),
      .rd_en     (rd_en),
      .rd_idx    (rd_idx),
      .rd_frame  (rd_frame),
      .rd_mapped (rd_mapped),
      .rsp_valid (rsp_valid),
      .rsp_hit   (rsp_hit),
      .rsp_fault (rsp_fault),
      .rsp_paddr (rsp_paddr)
   );

endmodule

// File: rtl/dxu_xlate_chk.sv
module dxu_xlate_chk #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned PAGE_BITS   = 12,
   parameter int unsigned MAX_ENTRIES = 512
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic              cfg_sel,
   input logic [ADDR_W-1:0] cfg_wdata,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_laddr,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic              rsp_fault,
   input logic [ADDR_W-1:0] rsp_paddr,
   input logic [ADDR_W-1:0] tbl_base,
   input logic [ADDR_W-1:0] tbl_limit
);

   localparam int unsigned PIDX_W = ADDR_W - PAGE_BITS;

   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);  // R2
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);  // R2
   AST_HIT_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $countones({rsp_hit, rsp_fault}) == 1);  // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_hit && !rsp_fault && rsp_paddr == '0));  // R10
   AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (!rsp_hit || rsp_paddr[PAGE_BITS-1:0] == $past(req_laddr[PAGE_BITS-1:0])));  // R3
   AST_ZERO_LIMIT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && tbl_limit == '0) |=> rsp_fault);  // R6
   AST_HIGH_PAGE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_laddr[ADDR_W-1:PAGE_BITS] >= PIDX_W'(MAX_ENTRIES)) |=> rsp_fault);  // R7
   AST_BASE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_sel) |=> tbl_base == {1'b0, $past(cfg_wdata[ADDR_W-2:0])});  // R8
   AST_LIMIT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel) |=> tbl_limit == $past(cfg_wdata));  // R8

endmodule

bind dxu_xlate dxu_xlate_chk #(
   .ADDR_W      (ADDR_W),
   .PAGE_BITS   (PAGE_BITS),
   .MAX_ENTRIES (MAX_ENTRIES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_sel   (cfg_sel),
   .cfg_wdata (cfg_wdata),
   .req_valid (req_valid),
   .req_laddr (req_laddr),
   .rsp_valid (rsp_valid),
   .rsp_hit   (rsp_hit),
   .rsp_fault (rsp_fault),
   .rsp_paddr (rsp_paddr),
   .tbl_base  (tbl_base),
   .tbl_limit (tbl_limit)
);

// File: tb/sim_dxu_xlate.sv
`timescale 1ns/1ps
module sim_dxu_xlate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        tbl_we = 1'b0;
   logic [11:0] tbl_off = '0;
   logic [31:0] tbl_wdata = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_laddr = '0;
   logic        rsp_valid, rsp_hit, rsp_fault;
   logic [31:0] rsp_paddr, tbl_base, tbl_limit;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dxu_xlate u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .tbl_we(tbl_we), .tbl_off(tbl_off), .tbl_wdata(tbl_wdata),
      .req_valid(req_valid), .req_laddr(req_laddr),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
      .rsp_paddr(rsp_paddr), .tbl_base(tbl_base), .tbl_limit(tbl_limit)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic tbl_write(input logic [11:0] off, input logic [31:0] d);
      @(negedge clk);
      tbl_we = 1'b1; tbl_off = off; tbl_wdata = d;
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   // exp_hit=1 expects a hit with exp_pa; exp_hit=0 expects a fault
   task automatic lookup(input logic [31:0] la, input bit exp_hit, input logic [31:0] exp_pa, input string req);
      @(negedge clk);
      req_valid = 1'b1; req_laddr = la;
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_valid == 1'b1, "R2 response strobe", {31'b0, rsp_valid}, 32'h1);
      check(rsp_hit == exp_hit && rsp_fault == !exp_hit, req, {30'b0, rsp_hit, rsp_fault}, {30'b0, exp_hit, !exp_hit});
      check(rsp_paddr == (exp_hit ? exp_pa : 32'h0), req, rsp_paddr, exp_hit ? exp_pa : 32'h0);
      @(negedge clk);
      check(!rsp_valid && !rsp_hit && !rsp_fault, "R10 idle after response", {29'b0, rsp_valid, rsp_hit, rsp_fault}, 32'h0);
   endtask

   task automatic t_reset;
      check(!rsp_valid && !rsp_hit && !rsp_fault, "R1 reset outputs", {29'b0, rsp_valid, rsp_hit, rsp_fault}, 32'h0);
      check(tbl_base == 32'h0, "R1 reset base", tbl_base, 32'h0);
      check(tbl_limit == 32'h0, "R1 reset limit", tbl_limit, 32'h0);
      lookup(32'h0000_0010, 1'b0, 32'h0, "R6 zero limit faults");
      cfg_write(1'b1, 32'h0000_1000);
      lookup(32'h0000_0010, 1'b0, 32'h0, "R1 entry 0 unmapped after reset");
      lookup(32'h0000_3F0E, 1'b0, 32'h0, "R1 entry 3 unmapped after reset");
   endtask

   task automatic t_translate;
      tbl_write(12'd24, 32'h1234_5ABC);
      lookup(32'h0000_3F0E, 1'b1, 32'h1234_5F0E, "R3 frame plus offset");
      lookup(32'h0000_3000, 1'b1, 32'h1234_5000, "R3 offset zero");
   endtask

   task automatic t_zero;
      tbl_write(12'd40, 32'h0000_0000);
      lookup(32'h0000_5000, 1'b0, 32'h0, "R4 zero frame faults");
      tbl_write(12'd48, 32'h0000_0123);
      lookup(32'h0000_6456, 1'b1, 32'h0000_0456, "R4 nonzero low-only frame maps");
   endtask

   task automatic t_owner;
      tbl_write(12'd28, 32'hDEAD_0000);
      lookup(32'h0000_3F0E, 1'b1, 32'h1234_5F0E, "R5 owner word leaves mapping");
      tbl_write(12'd60, 32'hBEEF_0000);
      lookup(32'h0000_7000, 1'b0, 32'h0, "R5 owner word does not map entry");
      tbl_write(12'd58, 32'hCAFE_0000);
      lookup(32'h0000_7000, 1'b0, 32'h0, "R5 misaligned offset ignored");
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      tbl_we = 1'b1; tbl_off = 12'd24; tbl_wdata = 32'h0BAD_0000;
      req_valid = 1'b1; req_laddr = 32'h0000_3F0E;
      @(negedge clk);
      tbl_we = 1'b0; req_valid = 1'b0;
      check(rsp_hit && rsp_paddr == 32'h1234_5F0E, "R9 same-cycle lookup sees old entry", rsp_paddr, 32'h1234_5F0E);
      lookup(32'h0000_3F0E, 1'b1, 32'h0BAD_0F0E, "R11 rewritten frame replaces mapping");
   endtask

   task automatic t_limit;
      tbl_write(12'd32, 32'h0004_4000);
      cfg_write(1'b1, 32'd32);
      lookup(32'h0000_3001, 1'b1, 32'h0BAD_0001, "R6 last live entry hits");
      lookup(32'h0000_4001, 1'b0, 32'h0, "R6 entry at count faults");
      cfg_write(1'b1, 32'd39);
      lookup(32'h0000_4001, 1'b0, 32'h0, "R6 partial entry bytes not live");
      cfg_write(1'b1, 32'd40);
      lookup(32'h0000_4001, 1'b1, 32'h0004_4001, "R6 count grows with limit");
      cfg_write(1'b1, 32'd0);
      lookup(32'h0000_3001, 1'b0, 32'h0, "R6 zero limit faults mapped entry");
   endtask

   task automatic t_high;
      cfg_write(1'b1, 32'hFFFF_FFF8);
      tbl_write(12'd4088, 32'hAAAA_B000);
      lookup(32'h001F_F123, 1'b1, 32'hAAAA_B123, "R7 entry 511 live at capped count");
      lookup(32'h0020_0123, 1'b0, 32'h0, "R7 page 512 faults");
      lookup(32'hFFFF_F000, 1'b0, 32'h0, "R7 top page faults");
      lookup(32'h0020_0000 | 32'h0000_3000, 1'b0, 32'h0, "R7 aliased index faults");
   endtask

   task automatic t_base;
      cfg_write(1'b0, 32'hFFFF_FFFF);
      check(tbl_base == 32'h7FFF_FFFF, "R8 base bit 31 masked", tbl_base, 32'h7FFF_FFFF);
      cfg_write(1'b1, 32'h8000_0123);
      check(tbl_limit == 32'h8000_0123, "R8 limit stored unchanged", tbl_limit, 32'h8000_0123);
      check(tbl_base == 32'h7FFF_FFFF, "R8 base held on limit write", tbl_base, 32'h7FFF_FFFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_translate();
      t_zero();
      t_owner();
      t_same_cycle();
      t_limit();
      t_high();
      t_base();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule